// File: doc/BRIEF.md
# I2C Bus Clear Sequence Generator

This block takes the downstream SCL and SDA lines for a short time to free a slave that may have been left in the middle of a transfer. A one-cycle start request, accepted while the generator is idle, launches a fixed sequence. SDA stays released while nine SCL clock pulses run. A slave that was sending data therefore sees eight data bits and a not-acknowledge, and it lets go of SDA. A STOP condition follows, and then a one-cycle done pulse tells the caller that the lines are handed back.

The sequence always runs in full, whatever state the bus was in before. The block has no bus-sense input. Both line outputs are open-drain style pull-low enables: a 1 pulls the wire low and a 0 releases it. Each SCL low phase and each SCL high phase lasts a programmable number of system clocks. The count is captured when a run is accepted. At 100 MHz a count of 500 gives a clock of about 100 kHz. Clock stretching, switching the bus between masters, and deciding when to clear the bus are left to the surrounding logic.

The controller has six states:
- IDLE: both lines released, not busy.
- PULSE_LO: SCL pulled low, SDA released.
- PULSE_HI: SCL released, SDA released.
- STOP_LO: SCL and SDA both pulled low.
- STOP_HI: SCL released, SDA still low.
- FINISH: both lines released, done raised.

Its transitions are:
- IDLE to PULSE_LO on an accepted start.
- PULSE_LO to PULSE_HI when the phase timer expires.
- PULSE_HI to PULSE_LO on expiry while fewer than nine pulses are complete.
- PULSE_HI to STOP_LO on expiry of the ninth high phase.
- STOP_LO to STOP_HI on expiry.
- STOP_HI to FINISH on expiry.
- FINISH to IDLE unconditionally.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, scl_pull_o, sda_pull_o, busy_o and done_o are all 0, and they stay 0 while no start is given.
- R2: A start_i high while idle is taken at that clock edge. From the next cycle busy_o is 1, scl_pull_o is 1 and sda_pull_o is 0.
- R3: Every run makes exactly 9 SCL pulses. Each pulse is N cycles with scl_pull_o=1 followed by N cycles with scl_pull_o=0. N is half_cycles_i as sampled at the accepted start, and a value of 0 is taken as 1.
- R4: sda_pull_o is 0 for the whole of the 9 pulses.
- R5: After the ninth high phase, scl_pull_o=1 and sda_pull_o=1 hold for N cycles. Then scl_pull_o=0 with sda_pull_o=1 holds for N cycles. Then sda_pull_o drops to 0 while scl_pull_o stays 0, which forms the STOP. SDA never changes while SCL is released, except at this release.
- R6: done_o is 1 for exactly one cycle, the cycle in which SDA is released for the STOP. busy_o falls to 0 on the cycle after that.
- R7: A start_i that arrives while busy_o is 1 is ignored. The current run keeps its timing and no extra run follows.
- R8: A change of half_cycles_i during a run has no effect on that run's timing.
- R9: A start given in the first idle cycle after a run begins a new complete run, with the new sampled N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the clear sequence |
| half_cycles_i | input | DIV_W | Length of each SCL phase in system clocks (0 is taken as 1) |
| busy_o | output | 1 | High from the cycle after an accepted start until one cycle after the STOP |
| done_o | output | 1 | One-cycle pulse at the STOP |
| scl_pull_o | output | 1 | Pull the downstream SCL low when 1 |
| sda_pull_o | output | 1 | Pull the downstream SDA low when 1 |

## Verification
All outputs are decoded straight from the state register. Each result is therefore due a whole number of edges after the start is taken: the first low phase begins one edge later, pulse i begins at 2iN, the STOP low phase at 18N, the SCL release at 19N, done at 20N, and the drop of busy at 20N+1. The bench drives start_i at a falling edge. It then compares all four outputs against this timeline at every falling edge up to 20N+1, so every check samples half a cycle after the edge that set the value. Starts and half_cycles_i changes during a run are applied at fixed offsets, and the same timeline must still hold.

// File: rtl/bclr_pkg.sv
package bclr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PULSE_LO = 3'd1,
        ST_PULSE_HI = 3'd2,
        ST_STOP_LO  = 3'd3,
        ST_STOP_HI  = 3'd4,
        ST_FINISH   = 3'd5
    } bclr_state_e;

endpackage

// File: rtl/bclr_phase_timer.sv
module bclr_phase_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] load_val_i,
    output logic             expire_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/bclr_pulse_counter.sv
module bclr_pulse_counter #(
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(NUM_PULSES + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(NUM_PULSES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
    import bclr_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int NUM_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] half_cycles_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             scl_pull_o,
    output logic             sda_pull_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    bclr_state_e      state_q, state_d;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] half_eff;
    logic             accept;
    logic             tmr_load;
    logic [DIV_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             pc_inc;
    logic             pc_last;

    assign half_eff = (half_cycles_i == '0) ? ONE : half_cycles_i;
    assign accept   = (state_q == ST_IDLE) && start_i;

    // Phase length is frozen at the accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= ONE;
        end else if (accept) begin
            half_q <= half_eff;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and sequencing controls
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = half_q - ONE;
        pc_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_PULSE_LO;
                    tmr_load = 1'b1;
                    tmr_val  = half_eff - ONE;
                end
            end
            ST_PULSE_LO: begin
                if (tmr_expire) begin
                    state_d  = ST_PULSE_HI;
                    tmr_load = 1'b1;
                end
            end
            ST_PULSE_HI: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    pc_inc   = 1'b1;
                    state_d  = pc_last ? ST_STOP_LO : ST_PULSE_LO;
                end
            end
            ST_STOP_LO: begin
                if (tmr_expire) begin
                    state_d  = ST_STOP_HI;
                    tmr_load = 1'b1;
                end
            end
            ST_STOP_HI: begin
                if (tmr_expire) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        busy_o     = 1'b1;
        done_o     = 1'b0;
        scl_pull_o = 1'b0;
        sda_pull_o = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy_o = 1'b0;
            ST_PULSE_LO: scl_pull_o = 1'b1;
            ST_PULSE_HI: scl_pull_o = 1'b0;
            ST_STOP_LO: begin
                scl_pull_o = 1'b1;
                sda_pull_o = 1'b1;
            end
            ST_STOP_HI:  sda_pull_o = 1'b1;
            ST_FINISH:   done_o = 1'b1;
            default:     busy_o = 1'b0;
        endcase
    end

    bclr_phase_timer #(
        .DIV_W(DIV_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expire_o  (tmr_expire)
    );

    bclr_pulse_counter #(
        .NUM_PULSES(NUM_PULSES)
    ) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept),
        .inc_i  (pc_inc),
        .last_o (pc_last)
    );

endmodule

// File: rtl/bclr_checker.sv
module bclr_checker #(
    parameter int NUM_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic scl_pull_o,
    input logic sda_pull_o
);

    localparam int RW = $clog2(NUM_PULSES + 3);

    logic          scl_prev;
    logic [RW-1:0] rel_cnt;

    // Counts SCL releases within one run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b0;
            rel_cnt  <= '0;
        end else begin
            scl_prev <= scl_pull_o;
            if (!busy_o) begin
                rel_cnt <= '0;
            end else if (scl_prev && !scl_pull_o) begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_pull_o && !sda_pull_o && !done_o)); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && scl_pull_o && !sda_pull_o)); // R2

    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rel_cnt == RW'(NUM_PULSES + 1))); // R3

    AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> scl_pull_o); // R4

    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> (!scl_pull_o && done_o)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R7

endmodule

bind i2c_bus_clear bclr_checker #(
    .NUM_PULSES(NUM_PULSES)
) u_bclr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .scl_pull_o(scl_pull_o),
    .sda_pull_o(sda_pull_o)
);

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DIV_W-1:0] half_cycles_i = '0;
    logic             busy_o, done_o, scl_pull_o, sda_pull_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    i2c_bus_clear #(.DIV_W(DIV_W), .NUM_PULSES(9)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .half_cycles_i(half_cycles_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp, input int k);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at step %0d: actual %b expected %b", req, what, k, act, exp);
        end
    endtask

    // Drives one run from start and compares every cycle against the timeline
    task automatic run_trace(input int drive_n, input bit poke_start,
                             input bit change_half, input string tag);
        int n;
        n = (drive_n == 0) ? 1 : drive_n;
        half_cycles_i = DIV_W'(drive_n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= 20 * n + 1; k++) begin
            logic e_busy, e_done, e_scl, e_sda;
            string rq;
            if (k < 18 * n) begin
                e_scl = ((k / n) % 2) == 0;
                e_sda = 1'b0; e_busy = 1'b1; e_done = 1'b0;
                rq = (k == 0) ? "R2" : "R3";
            end else if (k < 19 * n) begin
                e_scl = 1'b1; e_sda = 1'b1; e_busy = 1'b1; e_done = 1'b0; rq = "R5";
            end else if (k < 20 * n) begin
                e_scl = 1'b0; e_sda = 1'b1; e_busy = 1'b1; e_done = 1'b0; rq = "R5";
            end else if (k == 20 * n) begin
                e_scl = 1'b0; e_sda = 1'b0; e_busy = 1'b1; e_done = 1'b1; rq = "R6";
            end else begin
                e_scl = 1'b0; e_sda = 1'b0; e_busy = 1'b0; e_done = 1'b0; rq = "R6";
            end
            if (poke_start) rq = {rq, "/R7"};
            if (change_half) rq = {rq, "/R8"};
            check(rq, {tag, " scl_pull"}, scl_pull_o, e_scl, k);
            check((k < 18 * n) ? "R4" : rq, {tag, " sda_pull"}, sda_pull_o, e_sda, k);
            check(rq, {tag, " busy"}, busy_o, e_busy, k);
            check(rq, {tag, " done"}, done_o, e_done, k);
            start_i = poke_start && ((k == 2) || (k == 20 * n - 1) || (k == 20 * n));
            if (change_half && k == 1) half_cycles_i = DIV_W'(n + 3);
            if (k != 20 * n + 1) @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic test_reset();
        for (int i = 0; i < 4; i++) begin
            check("R1", "reset scl_pull", scl_pull_o, 1'b0, i);
            check("R1", "reset sda_pull", sda_pull_o, 1'b0, i);
            check("R1", "reset busy", busy_o, 1'b0, i);
            check("R1", "reset done", done_o, 1'b0, i);
            @(negedge clk);
        end
    endtask

    task automatic test_idle_after(input string tag);
        // R7: no extra run after an ignored start
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R7", {tag, " idle busy"}, busy_o, 1'b0, i);
            check("R7", {tag, " idle scl"}, scl_pull_o, 1'b0, i);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_trace(1, 1'b0, 1'b0, "N1");
        @(negedge clk);
        run_trace(3, 1'b0, 1'b0, "N3");
        @(negedge clk);
        run_trace(0, 1'b0, 1'b0, "N0");
        @(negedge clk);
        run_trace(4, 1'b1, 1'b0, "poke");
        test_idle_after("poke");
        run_trace(2, 1'b0, 1'b1, "hchg");
        // R9: back-to-back start in the first idle cycle
        run_trace(5, 1'b0, 1'b0, "R9 b2b");
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule